// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits between a processor's execution core and a 16-bit memory port. It holds up to six instruction bytes in arrival order and refills itself by reading whole 16-bit words from consecutive code addresses. A code address is a 16-bit segment and a 16-bit offset, combined into a 20-bit physical address. The execution core takes instruction bytes one at a time from the head of the queue.

The core can also ask for a data read or write through a separate operand port. An operand request wins over starting a new prefetch. A code read that has already started always finishes before the operand access begins. When the core takes a branch, it pulses the redirect input with a new segment and offset. The queue empties, and fetching starts again from that point. A code word that was still in flight when the redirect came is thrown away when it returns.

The memory port uses a request/acknowledge handshake. The request, address, direction and write data stay fixed until the cycle in which the acknowledge is high. Read data is valid in that same cycle.

Top module: `fetch_queue_top`

## Requirements
- R1: The queue never holds more than DEPTH (6) bytes. Bytes leave in the order they arrived, and `q_vld` is high exactly when at least one byte is held.
- R2: A code read is started only if three things hold: the queue, after the current cycle's updates, has at least two free slots; no operand request is pending; and the bus is idle or a code read is completing. The request appears in the following cycle.
- R3: Each accepted code word adds two bytes: `mem_rdata[7:0]` first, then `mem_rdata[15:8]`.
- R4: Each cycle with `q_take` and `q_vld` both high removes exactly the head byte. `q_take` while `q_vld` is low changes nothing.
- R5: An operand request pending when the bus becomes free is started before any code read. The operand access carries `opr_addr`, `opr_we` and `opr_wdata` to the memory port. `opr_ack` and `opr_rdata` follow the memory acknowledge and read data. A code read already in flight completes first.
- R6: A redirect empties the queue, so `q_vld` is low in the next cycle. Fetching then continues from the new segment and offset.
- R7: The fetch address is `segment*16 + offset`, with offset bit 0 cleared, taken modulo 2^20.
- R8: A code word acknowledged after a redirect, when its read began before that redirect, is discarded. A word acknowledged in the same cycle as a redirect is also discarded.
- R9: After each accepted code word, the word-aligned offset advances by 2, wrapping within 16 bits.
- R10: After a redirect to an odd offset, the first accepted word adds only its upper byte, `mem_rdata[15:8]`.
- R11: With the queue full and no operand request or redirect, the memory port stays idle.
- R12: `mem_req`, `mem_addr`, `mem_code` and `mem_we` hold until `mem_ack`. After reset, the first code read uses segment 0xFFFF and offset 0x0000, which is physical address 0xFFFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| redir_vld | input | 1 | One-cycle branch/redirect pulse |
| redir_seg | input | 16 | New code segment |
| redir_off | input | 16 | New code offset |
| q_take | input | 1 | Core removes the head byte |
| q_vld | output | 1 | Head byte is valid |
| q_byte | output | 8 | Head byte |
| opr_req | input | 1 | Operand access request, held until `opr_ack` |
| opr_we | input | 1 | Operand access is a write |
| opr_addr | input | 20 | Operand physical address |
| opr_wdata | input | 16 | Operand write data |
| opr_ack | output | 1 | Operand access completes this cycle |
| opr_rdata | output | 16 | Operand read data |
| mem_req | output | 1 | Memory request |
| mem_code | output | 1 | Current request is a code read |
| mem_we | output | 1 | Current request is a write |
| mem_addr | output | 20 | Memory physical address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |

## Verification
A stimulus or acknowledge seen at a clock edge affects the outputs one register stage later.
- A redirect clears `q_vld` at the next edge.
- An accepted code word makes its bytes visible at the next edge.
- A new request, whether code or operand, appears on `mem_req` one edge after the decision.
- `opr_ack` and `opr_rdata` are combinational on the acknowledge cycle.

The behavioural model advances on the same edge as the design. Every output is compared on the falling edge that follows, so each result is sampled in the cycle it is due. Directed cases cover the reset fetch address, an odd redirect, a word dropped after a flush, segment wrap, and operand priority over a running fetch. Random phases vary the memory latency, the take pattern, and the mix of operands and redirects.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_CODE = 2'd1,
    BUS_OPER = 2'd2
  } bus_state_e;

  // modular pointer advance for a ring whose size need not be a power of two
  function automatic int ring_add(input int ptr, input int step, input int size);
    int s;
    s = ptr + step;
    if (s >= size) s = s - size;
    return s;
  endfunction

endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
  parameter int DEPTH = 6,
  parameter int BW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          pop,
  input  logic [1:0]                    push_n,
  input  logic [BW-1:0]                 din0,
  input  logic [BW-1:0]                 din1,
  output logic [BW-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]    cnt,
  output logic [$clog2(DEPTH+1)-1:0]    cnt_nxt
);
  import pfq_pkg::*;

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [PW-1:0] rd_q, rd_nxt, wr_q, wr_nxt, wr_p1;
  logic [CW-1:0] cnt_q;
  logic          do_pop, we0, we1;
  logic [BW-1:0] slot_q [DEPTH];

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    wr_p1   = PW'(ring_add(int'(wr_q), 1, DEPTH));
    we0     = !clr && (push_n != 2'd0);
    we1     = !clr && (push_n == 2'd2);
    if (clr) begin
      rd_nxt  = '0;
      wr_nxt  = '0;
      cnt_nxt = '0;
    end else begin
      rd_nxt  = do_pop ? PW'(ring_add(int'(rd_q), 1, DEPTH)) : rd_q;
      wr_nxt  = PW'(ring_add(int'(wr_q), int'(push_n), DEPTH));
      cnt_nxt = cnt_q + CW'(push_n) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_nxt;
      wr_q  <= wr_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  // datapath storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we0 && (wr_q == PW'(i)))
        slot_q[i] <= din0;
      else if (we1 && (wr_p1 == PW'(i)))
        slot_q[i] <= din1;
    end
  end

  assign head = slot_q[rd_q];
  assign cnt  = cnt_q;

endmodule

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
  parameter int          SEG_W   = 16,
  parameter int          OFF_W   = 16,
  parameter int          PA_W    = 20,
  parameter logic [15:0] RST_SEG = 16'hFFFF,
  parameter logic [15:0] RST_OFF = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir,
  input  logic [SEG_W-1:0]  redir_seg,
  input  logic [OFF_W-1:0]  redir_off,
  input  logic              adv,
  output logic [PA_W-1:0]   phys_nxt,
  output logic              skip_lo
);
  localparam int SHIFT = PA_W - SEG_W;

  logic [SEG_W-1:0] seg_q, seg_nxt;
  logic [OFF_W-1:0] off_q, off_nxt, off_al;
  logic             skip_q, skip_nxt;

  always_comb begin
    seg_nxt  = seg_q;
    off_nxt  = off_q;
    skip_nxt = skip_q;
    if (redir) begin
      seg_nxt  = redir_seg;
      off_nxt  = redir_off;
      skip_nxt = redir_off[0];
    end else if (adv) begin
      off_nxt  = {off_q[OFF_W-1:1], 1'b0} + OFF_W'(2);
      skip_nxt = 1'b0;
    end
    off_al   = {off_nxt[OFF_W-1:1], 1'b0};
    phys_nxt = {seg_nxt, {SHIFT{1'b0}}} + PA_W'(off_al);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_W'(RST_SEG);
      off_q  <= OFF_W'(RST_OFF);
      skip_q <= RST_OFF[0];
    end else begin
      seg_q  <= seg_nxt;
      off_q  <= off_nxt;
      skip_q <= skip_nxt;
    end
  end

  assign skip_lo = skip_q;

endmodule

// File: rtl/pfq_bus_ctl.sv
module pfq_bus_ctl #(
  parameter int PA_W   = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir,
  input  logic              room,
  input  logic [PA_W-1:0]   code_addr,
  input  logic              opr_req,
  input  logic              opr_we,
  input  logic [PA_W-1:0]   opr_addr,
  input  logic [DATA_W-1:0] opr_wdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_code,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              opr_ack,
  output logic              word_ok
);
  import pfq_pkg::*;

  bus_state_e        st_q, st_nxt;
  logic [PA_W-1:0]   addr_q, addr_nxt;
  logic [DATA_W-1:0] wd_q, wd_nxt;
  logic              we_q, we_nxt;
  logic              disc_q, disc_nxt;
  logic              pick, load;

  always_comb begin
    pick   = (st_q == BUS_IDLE) || ((st_q == BUS_CODE) && mem_ack);
    st_nxt = st_q;
    if (pick) begin
      if (opr_req)   st_nxt = BUS_OPER;
      else if (room) st_nxt = BUS_CODE;
      else           st_nxt = BUS_IDLE;
    end else if ((st_q == BUS_OPER) && mem_ack) begin
      st_nxt = BUS_IDLE;
    end
    load     = pick && (st_nxt != BUS_IDLE);
    addr_nxt = addr_q;
    wd_nxt   = wd_q;
    we_nxt   = we_q;
    if (load) begin
      if (st_nxt == BUS_OPER) begin
        addr_nxt = opr_addr;
        wd_nxt   = opr_wdata;
        we_nxt   = opr_we;
      end else begin
        addr_nxt = code_addr;
        we_nxt   = 1'b0;
      end
    end
    disc_nxt = disc_q;
    if ((st_q == BUS_CODE) && mem_ack) disc_nxt = 1'b0;
    else if ((st_q == BUS_CODE) && redir) disc_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BUS_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      disc_q <= disc_nxt;
      if (load) begin
        addr_q <= addr_nxt;
        wd_q   <= wd_nxt;
        we_q   <= we_nxt;
      end
    end
  end

  assign mem_req   = (st_q != BUS_IDLE);
  assign mem_code  = (st_q == BUS_CODE);
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign opr_ack   = (st_q == BUS_OPER) && mem_ack;
  assign word_ok   = (st_q == BUS_CODE) && mem_ack && !disc_q && !redir;

endmodule

// File: rtl/fetch_queue_top.sv
module fetch_queue_top #(
  parameter int          DEPTH   = 6,
  parameter int          SEG_W   = 16,
  parameter int          OFF_W   = 16,
  parameter int          PA_W    = 20,
  parameter int          DATA_W  = 16,
  parameter logic [15:0] RST_SEG = 16'hFFFF,
  parameter logic [15:0] RST_OFF = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_vld,
  input  logic [SEG_W-1:0]  redir_seg,
  input  logic [OFF_W-1:0]  redir_off,
  input  logic              q_take,
  output logic              q_vld,
  output logic [DATA_W/2-1:0] q_byte,
  input  logic              opr_req,
  input  logic              opr_we,
  input  logic [PA_W-1:0]   opr_addr,
  input  logic [DATA_W-1:0] opr_wdata,
  output logic              opr_ack,
  output logic [DATA_W-1:0] opr_rdata,
  output logic              mem_req,
  output logic              mem_code,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BW = DATA_W / 2;
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0]   q_cnt, cnt_nxt;
  logic [PA_W-1:0] code_addr;
  logic            skip_lo, word_ok, room;
  logic [1:0]      push_n;
  logic [BW-1:0]   din0;

  assign room   = (int'(cnt_nxt) <= DEPTH - 2);
  assign push_n = word_ok ? (skip_lo ? 2'd1 : 2'd2) : 2'd0;
  assign din0   = skip_lo ? mem_rdata[DATA_W-1:BW] : mem_rdata[BW-1:0];

  pfq_byte_fifo #(.DEPTH(DEPTH), .BW(BW)) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (redir_vld),
    .pop     (q_take),
    .push_n  (push_n),
    .din0    (din0),
    .din1    (mem_rdata[DATA_W-1:BW]),
    .head    (q_byte),
    .cnt     (q_cnt),
    .cnt_nxt (cnt_nxt)
  );

  pfq_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W),
    .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
  ) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .redir     (redir_vld),
    .redir_seg (redir_seg),
    .redir_off (redir_off),
    .adv       (word_ok),
    .phys_nxt  (code_addr),
    .skip_lo   (skip_lo)
  );

  pfq_bus_ctl #(.PA_W(PA_W), .DATA_W(DATA_W)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .redir     (redir_vld),
    .room      (room),
    .code_addr (code_addr),
    .opr_req   (opr_req),
    .opr_we    (opr_we),
    .opr_addr  (opr_addr),
    .opr_wdata (opr_wdata),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_code  (mem_code),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .opr_ack   (opr_ack),
    .word_ok   (word_ok)
  );

  assign q_vld     = (q_cnt != '0);
  assign opr_rdata = mem_rdata;

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 6,
  parameter int CW    = 3,
  parameter int PA_W  = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redir_vld,
  input logic            opr_req,
  input logic            q_vld,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_code,
  input logic [PA_W-1:0] mem_addr,
  input logic [CW-1:0]   q_cnt
);
  logic prev_req, prev_ack, prev_opr, code_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_req <= 1'b0;
      prev_ack <= 1'b0;
      prev_opr <= 1'b0;
    end else begin
      prev_req <= mem_req;
      prev_ack <= mem_ack;
      prev_opr <= opr_req;
    end
  end

  assign code_start = mem_req && mem_code && (!prev_req || prev_ack);

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_cnt) <= DEPTH); // R1
  AST_ROOM_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    code_start |-> (int'(q_cnt) <= DEPTH - 2)); // R2
  AST_OPER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    code_start |-> !prev_opr); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |=> !q_vld); // R6
  AST_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_cnt) == DEPTH && !opr_req && !mem_req && !redir_vld) |=> !mem_req); // R11
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_code))); // R12

endmodule

bind fetch_queue_top pfq_checker #(.DEPTH(DEPTH), .CW(CW), .PA_W(PA_W)) i_pfq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .redir_vld (redir_vld),
  .opr_req   (opr_req),
  .q_vld     (q_vld),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_code  (mem_code),
  .mem_addr  (mem_addr),
  .q_cnt     (q_cnt)
);

// File: tb/test_fetch_queue_top.sv
`timescale 1ns/1ps
module test_fetch_queue_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        redir_vld;
  logic [15:0] redir_seg, redir_off;
  logic        q_take;
  logic        q_vld;
  logic [7:0]  q_byte;
  logic        opr_req, opr_we;
  logic [19:0] opr_addr;
  logic [15:0] opr_wdata;
  logic        opr_ack;
  logic [15:0] opr_rdata;
  logic        mem_req, mem_code, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack;
  logic [15:0] mem_rdata;

  always #5 clk = ~clk;

  fetch_queue_top i_fetch_queue_top (
    .clk(clk), .rst_n(rst_n),
    .redir_vld(redir_vld), .redir_seg(redir_seg), .redir_off(redir_off),
    .q_take(q_take), .q_vld(q_vld), .q_byte(q_byte),
    .opr_req(opr_req), .opr_we(opr_we), .opr_addr(opr_addr), .opr_wdata(opr_wdata),
    .opr_ack(opr_ack), .opr_rdata(opr_rdata),
    .mem_req(mem_req), .mem_code(mem_code), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] fb(input logic [19:0] a);
    return a[7:0] ^ a[19:12];
  endfunction

  function automatic logic [15:0] mword(input logic [19:0] a);
    return {fb({a[19:1], 1'b1}), fb({a[19:1], 1'b0})};
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o[15:1], 1'b0};
  endfunction

  // ---------------- memory responder ----------------
  int          lat = 1;
  int          wait_cnt = 0;
  logic [19:0] wr_seen_addr;
  logic [15:0] wr_seen_data;

  always @(negedge clk) begin
    if (!rst_n || !mem_req) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else if (wait_cnt >= lat) begin
      mem_ack   = 1'b1;
      mem_rdata = mword(mem_addr);
      if (mem_we && !mem_code) begin
        wr_seen_addr = mem_addr;
        wr_seen_data = mem_wdata;
      end
      wait_cnt = 0;
    end else begin
      mem_ack = 1'b0;
      wait_cnt++;
    end
  end

  // ---------------- take driver ----------------
  bit take_en = 0;
  always @(negedge clk) begin
    #1;
    q_take = take_en && ($urandom % 4 != 0);
  end

  // ---------------- behavioural reference ----------------
  int          st;        // 0 idle, 1 code, 2 operand
  logic [7:0]  mq[$];
  logic [15:0] pseg, poff;
  bit          skip, disc, m_we;
  logic [19:0] m_addr;
  logic [15:0] m_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      st = 0; mq.delete(); pseg = 16'hFFFF; poff = 16'h0000;
      skip = 0; disc = 0; m_we = 0; m_addr = '0; m_wd = '0;
    end else begin
      bit ack_now;
      int st_old;
      ack_now = mem_ack;
      st_old  = st;
      if (q_take && mq.size() > 0) void'(mq.pop_front());
      if (redir_vld) begin
        mq.delete();
        disc = (st_old == 1) && !ack_now;
        pseg = redir_seg; poff = redir_off; skip = redir_off[0];
      end else if (st_old == 1 && ack_now) begin
        if (disc) disc = 0;
        else begin
          if (!skip) mq.push_back(mem_rdata[7:0]);
          mq.push_back(mem_rdata[15:8]);
          skip = 0;
          poff = {poff[15:1], 1'b0} + 16'd2;
        end
      end
      if (st_old == 0 || (st_old == 1 && ack_now)) begin
        if (opr_req) begin
          st = 2; m_addr = opr_addr; m_we = opr_we; m_wd = opr_wdata;
        end else if (mq.size() <= 4) begin
          st = 1; m_addr = phys(pseg, poff); m_we = 0;
        end else st = 0;
      end else if (st_old == 2 && ack_now) st = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(q_vld === (mq.size() > 0), "R1 R4 R6 q_vld", q_vld, mq.size() > 0);
      if (mq.size() > 0)
        chk(q_byte === mq[0], "R1 R3 R4 R8 R10 q_byte", q_byte, mq[0]);
      chk(mem_req === (st != 0), "R2 R5 R11 mem_req", mem_req, st != 0);
      if (st != 0) begin
        chk(mem_code === (st == 1), "R2 R5 mem_code", mem_code, st == 1);
        chk(mem_addr === m_addr, "R7 R9 R12 mem_addr", mem_addr, m_addr);
        if (st == 2) begin
          chk(mem_we === m_we, "R5 mem_we", mem_we, m_we);
          if (m_we) chk(mem_wdata === m_wd, "R5 mem_wdata", mem_wdata, m_wd);
        end
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic redirect(input logic [15:0] s, input logic [15:0] o);
    @(negedge clk); #1;
    redir_vld = 1; redir_seg = s; redir_off = o;
    @(negedge clk); #1;
    redir_vld = 0;
  endtask

  task automatic wait_vld();
    for (int i = 0; i < 100; i++) begin
      if (q_vld) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic operand(input bit we, input logic [19:0] a, input logic [15:0] d);
    bit got;
    @(negedge clk); #1;
    opr_req = 1; opr_we = we; opr_addr = a; opr_wdata = d;
    got = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (opr_ack) begin got = 1; break; end
    end
    chk(got, "R5 opr_ack seen", got, 1);
    if (got && !we) chk(opr_rdata === mword(a), "R5 opr_rdata", opr_rdata, mword(a));
    @(negedge clk); #1;
    opr_req = 0;
    if (got && we) begin
      chk(wr_seen_addr === a, "R5 write addr", wr_seen_addr, a);
      chk(wr_seen_data === d, "R5 write data", wr_seen_data, d);
    end
  endtask

  initial begin
    #1_600_000;
    chk(0, "R12 watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    rst_n = 0; redir_vld = 0; redir_seg = '0; redir_off = '0;
    opr_req = 0; opr_we = 0; opr_addr = '0; opr_wdata = '0;
    q_take = 0; mem_ack = 0; mem_rdata = '0;
    step(3);
    chk(q_vld === 1'b0, "R1 reset q_vld", q_vld, 0);
    chk(mem_req === 1'b0, "R12 reset mem_req", mem_req, 0);
    rst_n = 1;
    step(1);
    chk(mem_req === 1'b1, "R12 first fetch request", mem_req, 1);
    chk(mem_addr === 20'hFFFF0, "R12 R7 reset fetch address", mem_addr, 20'hFFFF0);

    // fill with no consumer, bus must go quiet
    step(40);
    for (int i = 0; i < 5; i++) begin
      chk(mem_req === 1'b0, "R11 full queue bus idle", mem_req, 0);
      step(1);
    end

    // streaming with zero wait
    take_en = 1; lat = 0;
    step(100);

    // odd redirect: first byte is the upper half
    take_en = 0; lat = 1;
    redirect(16'h1234, 16'h0011);
    wait_vld();
    chk(q_byte === fb(20'h12351), "R10 odd redirect first byte", q_byte, fb(20'h12351));

    // flush while a code word is in flight
    lat = 5;
    redirect(16'h3000, 16'h0000);
    redirect(16'h2000, 16'h0000);
    wait_vld();
    chk(q_byte === fb(20'h20000), "R8 stale word dropped", q_byte, fb(20'h20000));

    // operand priority against running prefetch
    take_en = 1; lat = 3;
    operand(0, 20'h0ABCD, 16'h0000);
    operand(1, 20'h12345, 16'hBEEF);

    // segment wrap of the physical address
    take_en = 0; lat = 1;
    step(40);
    redirect(16'hFFFF, 16'hFFFE);
    chk(mem_req === 1'b1, "R6 refetch after redirect", mem_req, 1);
    chk(mem_addr === 20'h0FFEE, "R7 wrapped physical address", mem_addr, 20'h0FFEE);
    step(20);

    // mixed random phase
    take_en = 1;
    for (int it = 0; it < 250; it++) begin
      int r;
      r = $urandom % 8;
      case (r)
        0: redirect(16'($urandom), 16'($urandom));
        1: operand(0, 20'($urandom), 16'h0000);
        2: operand(1, 20'($urandom), 16'($urandom));
        3: lat = $urandom % 4;
        4: take_en = ($urandom % 4 != 0);
        default: step(1 + $urandom % 6);
      endcase
    end
    take_en = 1;
    step(30);
    wrap_up();
  end

endmodule